// File: doc/BRIEF.md
# SPI NOR Flash Erase and Program Sequencer

This block carries out sector erase and page program on a single-lane SPI NOR flash without software toggling pins bit by bit. A client presents one request made of an operation code, a 24-bit flash address and a byte count. For a program request, it then streams the payload bytes over a ready/valid byte port. The engine frames every transaction with chip select. It first waits for the flash to report idle, then sends a stand-alone write-enable frame, then the erase or program command with its address and any payload. It waits once more until the flash is idle and then raises a one-cycle done pulse.

The serial clock comes from the system clock divided by `CLK_DIV`, which must be 2 or more, and follows SPI mode 0. Each bit has a low half of `CLK_DIV - CLK_DIV/2` system cycles and a high half of `CLK_DIV/2` cycles. Status polling is a complete read-status transaction, repeated as often as needed. A synchronous abort drops chip select and returns the engine to idle at any point.

Top module: `spi_nor_prog_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `wr_ready` are 0.
- R2: The bus runs in SPI mode 0 and sends every byte MSB first. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled at the last system cycle of the high half. The high half lasts `CLK_DIV/2` cycles, every frame carries a whole number of bytes, and `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R3: Before the command, the engine repeats a status frame until status bit 0 reads 0. A status frame is opcode 0x05 followed by one byte read from `spi_miso`. Every other status bit is ignored.
- R4: Write enable is sent as a frame of its own, holding only opcode 0x06, after the first poll and before the command frame.
- R5: The command frame is an opcode followed by the address as three bytes, high byte first. `req_op`=0 selects sector erase with opcode 0x20, and the low `SECTOR_BITS` address bits (12 by default) are cleared. `req_op`=1 selects page program with opcode 0x02, and the address is sent unchanged.
- R6: For a program request, the payload follows the address bytes in the same frame. One byte is taken per `wr_valid`&&`wr_ready` handshake, and bytes are sent in the order received. `wr_ready` is high only during this data phase, while `spi_cs_n` is 0. The byte count is `req_len` clamped to `PAGE_BYTES`, and a count of 0 sends no payload.
- R7: After the command frame, status frames repeat until bit 0 reads 0. Then `done` is high for exactly one cycle, with `spi_cs_n` already 1. `busy` is high from the cycle after acceptance until `done`.
- R8: Between any two frames of an operation, `spi_cs_n` stays high for at least `CLK_DIV` system cycles.
- R9: A request presented while `busy` is 1 is ignored: it produces no frame and no extra `done`.
- R10: In the cycle after `abort` is 1, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy` and `wr_ready` are 0. No `done` follows. A later request runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Synchronous abort back to idle |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 1 | 0 = sector erase, 1 = page program |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Requested payload bytes (program only) |
| wr_valid | input | 1 | Payload byte available |
| wr_data | input | 8 | Payload byte |
| wr_ready | output | 1 | Engine takes a payload byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with `CLK_DIV` = 3 and `PAGE_BYTES` = 16. The odd divider gives unequal halves: two cycles low and a one-cycle high phase. That puts the sampling edge in the same cycle as the rise it follows and tests the `MOSI` hold and the deselect counting at their tightest. The small page makes the clamp reachable with a short stream, including under a stalling payload source. A flash model on the bench returns a status byte that always has bit 1 set and can hold bit 0 busy for a chosen number of polls, so both poll loops and the bit-0-only decision are exercised.

// File: rtl/spi_nor_prog_pkg.sv
package spi_nor_prog_pkg;

    localparam int ADDR_W = 24;

    localparam logic [7:0] OPC_WR_EN   = 8'h06;
    localparam logic [7:0] OPC_PROGRAM = 8'h02;
    localparam logic [7:0] OPC_ERASE   = 8'h20;
    localparam logic [7:0] OPC_STATUS  = 8'h05;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_FETCH,
        PH_WAIT,
        PH_DESEL
    } phase_e;

    typedef enum logic [2:0] {
        ST_POLL_PRE,
        ST_WR_EN,
        ST_CMD,
        ST_POLL_POST,
        ST_FINISH
    } step_e;

endpackage

// File: rtl/spi_nor_req_fmt.sv
module spi_nor_req_fmt
    import spi_nor_prog_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int PAGE_BYTES  = 256,
    parameter int SECTOR_BITS = 12,
    parameter int CNT_W       = 9
) (
    input  logic              op_prog,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CNT_W-1:0]  len_out
);

    localparam logic [ADDR_W-1:0] SECT_MASK =
        ~((ADDR_W'(1) << SECTOR_BITS) - ADDR_W'(1));

    // erase targets the start of the enclosing sector
    always_comb begin
        if (op_prog) begin
            addr_out = addr_in;
        end else begin
            addr_out = addr_in & SECT_MASK;
        end
    end

    // payload count never exceeds one page
    always_comb begin
        if (32'(len_in) > PAGE_BYTES) begin
            len_out = CNT_W'(PAGE_BYTES);
        end else begin
            len_out = CNT_W'(len_in);
        end
    end

endmodule

// File: rtl/spi_nor_byte_shifter.sv
module spi_nor_byte_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       rx_lsb,
    output logic       byte_done
);

    localparam int HALF_HI = CLK_DIV / 2;
    localparam int HALF_LO = CLK_DIV - HALF_HI;
    localparam int CW      = $clog2(CLK_DIV + 1);

    typedef struct packed {
        logic          active;
        logic          hi;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } shift_t;

    localparam shift_t SHIFT_RST = '{
        active: 1'b0, hi: 1'b0, cnt: '0, bitn: '0,
        tx: '0, rx: '0, done: 1'b0
    };

    shift_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (kill) begin
            s_d.active = 1'b0;
            s_d.hi     = 1'b0;
            s_d.cnt    = '0;
            s_d.bitn   = '0;
        end else if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.hi     = 1'b0;
                s_d.cnt    = '0;
                s_d.bitn   = '0;
                s_d.tx     = tx_byte;
            end
        end else if (!s_q.hi) begin
            // low half: data bit already on the line
            if (s_q.cnt == CW'(HALF_LO - 1)) begin
                s_d.hi  = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else begin
            // high half ends: capture input, move to next bit
            if (s_q.cnt == CW'(HALF_HI - 1)) begin
                s_d.hi  = 1'b0;
                s_d.cnt = '0;
                s_d.tx  = {s_q.tx[6:0], 1'b0};
                s_d.rx  = {s_q.rx[6:0], miso};
                if (s_q.bitn == 3'd7) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                    s_d.bitn   = '0;
                end else begin
                    s_d.bitn = s_q.bitn + 3'd1;
                end
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SHIFT_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk      = s_q.hi;
    assign mosi      = s_q.tx[7];
    assign rx_lsb    = s_q.rx[0];
    assign byte_done = s_q.done;

endmodule

// File: rtl/spi_nor_seq_ctrl.sv
module spi_nor_seq_ctrl
    import spi_nor_prog_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int CNT_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr_fmt,
    input  logic [CNT_W-1:0]  req_len_fmt,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_done,
    input  logic              sh_rx_lsb
);

    localparam int DW = $clog2(CLK_DIV + 1);
    localparam logic [CNT_W-1:0] HDR_BYTES = CNT_W'(4);

    typedef struct packed {
        phase_e            phase;
        step_e             step;
        logic              op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  idx;
        logic [DW-1:0]     dcnt;
        logic              cs_n;
        logic              done;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        phase: PH_IDLE, step: ST_POLL_PRE, op: 1'b0, addr: '0,
        len: '0, idx: '0, dcnt: '0, cs_n: 1'b1, done: 1'b0
    };

    ctrl_t c_d, c_q;

    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] nxt_idx;
    logic [7:0]       hdr_byte;

    // bytes in the frame belonging to the current step
    always_comb begin
        unique case (c_q.step)
            ST_POLL_PRE, ST_POLL_POST: frame_len = CNT_W'(2);
            ST_WR_EN:                  frame_len = CNT_W'(1);
            ST_CMD:                    frame_len = HDR_BYTES + (c_q.op ? c_q.len : '0);
            default:                   frame_len = CNT_W'(1);
        endcase
    end

    // opcode, address and filler bytes
    always_comb begin
        hdr_byte = 8'h00;
        unique case (c_q.step)
            ST_POLL_PRE, ST_POLL_POST: begin
                hdr_byte = (c_q.idx == '0) ? OPC_STATUS : 8'h00;
            end
            ST_WR_EN: hdr_byte = OPC_WR_EN;
            ST_CMD: begin
                if (c_q.idx == CNT_W'(0)) begin
                    hdr_byte = c_q.op ? OPC_PROGRAM : OPC_ERASE;
                end else if (c_q.idx == CNT_W'(1)) begin
                    hdr_byte = c_q.addr[23:16];
                end else if (c_q.idx == CNT_W'(2)) begin
                    hdr_byte = c_q.addr[15:8];
                end else begin
                    hdr_byte = c_q.addr[7:0];
                end
            end
            default: hdr_byte = 8'h00;
        endcase
    end

    assign nxt_idx = c_q.idx + CNT_W'(1);

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    c_d.op    = req_op;
                    c_d.addr  = req_addr_fmt;
                    c_d.len   = req_len_fmt;
                    c_d.step  = ST_POLL_PRE;
                    c_d.idx   = '0;
                    c_d.cs_n  = 1'b0;
                    c_d.phase = PH_START;
                end
            end
            PH_START: c_d.phase = PH_WAIT;
            PH_FETCH: begin
                if (wr_valid) begin
                    c_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (sh_done) begin
                    if (nxt_idx < frame_len) begin
                        c_d.idx   = nxt_idx;
                        c_d.phase = (c_q.step == ST_CMD && nxt_idx >= HDR_BYTES)
                                    ? PH_FETCH : PH_START;
                    end else begin
                        c_d.cs_n  = 1'b1;
                        c_d.phase = PH_DESEL;
                        c_d.dcnt  = '0;
                        c_d.idx   = '0;
                        unique case (c_q.step)
                            ST_POLL_PRE:  if (!sh_rx_lsb) c_d.step = ST_WR_EN;
                            ST_WR_EN:     c_d.step = ST_CMD;
                            ST_CMD:       c_d.step = ST_POLL_POST;
                            ST_POLL_POST: if (!sh_rx_lsb) c_d.step = ST_FINISH;
                            default:      c_d.step = ST_FINISH;
                        endcase
                    end
                end
            end
            PH_DESEL: begin
                if (c_q.dcnt == DW'(CLK_DIV - 1)) begin
                    if (c_q.step == ST_FINISH) begin
                        c_d.phase = PH_IDLE;
                        c_d.done  = 1'b1;
                    end else begin
                        c_d.cs_n  = 1'b0;
                        c_d.phase = PH_START;
                    end
                end else begin
                    c_d.dcnt = c_q.dcnt + DW'(1);
                end
            end
            default: c_d = CTRL_RST;
        endcase
        if (abort) begin
            c_d = CTRL_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTRL_RST;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_ready = (c_q.phase == PH_FETCH);
    assign sh_start = (c_q.phase == PH_START) || (c_q.phase == PH_FETCH && wr_valid);
    assign sh_tx    = (c_q.phase == PH_FETCH) ? wr_data : hdr_byte;
    assign busy     = (c_q.phase != PH_IDLE);
    assign done     = c_q.done;
    assign cs_n     = c_q.cs_n;

endmodule

// File: rtl/spi_nor_prog_engine.sv
module spi_nor_prog_engine
    import spi_nor_prog_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int PAGE_BYTES  = 256,
    parameter int SECTOR_BITS = 12,
    parameter int LEN_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int CNT_W = $clog2(PAGE_BYTES + 5);

    logic [ADDR_W-1:0] addr_fmt;
    logic [CNT_W-1:0]  len_fmt;
    logic              sh_start;
    logic [7:0]        sh_tx;
    logic              sh_done;
    logic              sh_rx_lsb;

    spi_nor_req_fmt #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .SECTOR_BITS(SECTOR_BITS),
        .CNT_W      (CNT_W)
    ) u_fmt (
        .op_prog (req_op),
        .addr_in (req_addr),
        .len_in  (req_len),
        .addr_out(addr_fmt),
        .len_out (len_fmt)
    );

    spi_nor_seq_ctrl #(
        .CLK_DIV(CLK_DIV),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (abort),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr_fmt(addr_fmt),
        .req_len_fmt (len_fmt),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .busy        (busy),
        .done        (done),
        .cs_n        (spi_cs_n),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .sh_done     (sh_done),
        .sh_rx_lsb   (sh_rx_lsb)
    );

    spi_nor_byte_shifter #(
        .CLK_DIV(CLK_DIV)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (abort),
        .start    (sh_start),
        .tx_byte  (sh_tx),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .rx_lsb   (sh_rx_lsb),
        .byte_done(sh_done)
    );

endmodule

// File: rtl/spi_nor_prog_engine_chk.sv
module spi_nor_prog_engine_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic busy,
    input logic done,
    input logic wr_ready,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);

    localparam int GW = $clog2(CLK_DIV + 2) + 1;

    logic [GW-1:0] hi_cnt;

    // cycles chip select has been high, saturating; reset and abort count as long idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= GW'(CLK_DIV);
        end else if (abort) begin
            hi_cnt <= GW'(CLK_DIV);
        end else if (spi_cs_n) begin
            hi_cnt <= (hi_cnt >= GW'(CLK_DIV)) ? hi_cnt : hi_cnt + GW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_ready_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!spi_cs_n && busy));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !busy));

    p_deselect_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= GW'(CLK_DIV)));

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (spi_cs_n && !busy && !wr_ready && !done));

endmodule

bind spi_nor_prog_engine spi_nor_prog_engine_chk #(
    .CLK_DIV(CLK_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .busy    (busy),
    .done    (done),
    .wr_ready(wr_ready),
    .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi)
);

// File: tb/spi_nor_prog_engine_test.sv
module spi_nor_prog_engine_test;

    localparam int DIV  = 3;
    localparam int PAGE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        wr_valid;
    logic [7:0]  wr_data;
    logic        wr_ready;
    logic        busy;
    logic        done;
    logic        spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spi_nor_prog_engine #(
        .CLK_DIV   (DIV),
        .PAGE_BYTES(PAGE),
        .SECTOR_BITS(12),
        .LEN_W     (16)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_addr (req_addr),
        .req_len  (req_len),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .busy     (busy),
        .done     (done),
        .spi_cs_n (spi_cs_n),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 29) + 8'h3C);
    endfunction

    // ---------------- payload source ----------------
    logic stall = 1'b0;
    logic tog = 1'b0;
    int   feed_idx = 0;

    always @(posedge clk) begin
        tog <= ~tog;
        if (!busy) feed_idx <= 0;
        else if (wr_valid && wr_ready) feed_idx <= feed_idx + 1;
    end
    assign wr_valid = !stall || tog;
    assign wr_data  = pat(feed_idx);

    // ---------------- flash model and bus monitor ----------------
    int   arm_id = 0;
    int   arm_pre = 0;
    int   arm_post = 0;
    int   seen_arm = 0;
    int   busy_left = 0;
    int   post_busy = 0;
    int   nframes = 0;
    int   flen [0:15];
    logic [7:0] fb [0:15][0:23];
    int   bitc = 0;
    int   bytec = 0;
    logic [7:0] shr = '0;
    logic prev_cs = 1'b1;
    logic prev_sc = 1'b0;
    logic prev_mosi = 1'b0;
    int   gap_run = 0;
    int   min_gap = 1000;
    int   mosi_viol = 0;
    int   partial_viol = 0;
    int   done_cnt = 0;
    int   hi_run = 0;
    int   hi_min = 1000;
    int   hi_max = 0;
    logic miso_q = 1'b0;

    assign spi_miso = miso_q;

    always @(negedge clk) begin
        logic [7:0] nb;
        logic [7:0] status;
        if (arm_id != seen_arm) begin
            seen_arm     = arm_id;
            busy_left    = arm_pre;
            post_busy    = arm_post;
            nframes      = 0;
            done_cnt     = 0;
            min_gap      = 1000;
            mosi_viol    = 0;
            partial_viol = 0;
            hi_min       = 1000;
            hi_max       = 0;
        end
        status = {6'b0, 1'b1, (busy_left > 0)};
        if (done) done_cnt++;
        if (spi_cs_n) gap_run++;
        if (prev_cs && !spi_cs_n) begin
            if (nframes > 0 && gap_run < min_gap) min_gap = gap_run;
            bitc  = 0;
            bytec = 0;
        end
        if (spi_sclk) hi_run++;
        if (prev_sc && !spi_sclk) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (spi_sclk && (spi_mosi != prev_mosi)) mosi_viol++;
        if (!spi_cs_n && !prev_sc && spi_sclk) begin
            nb  = {shr[6:0], spi_mosi};
            shr = nb;
            bitc++;
            if (bitc == 8) begin
                if (nframes < 16 && bytec < 24) fb[nframes][bytec] = nb;
                bytec++;
                bitc = 0;
            end
        end
        if (!spi_cs_n && prev_sc && !spi_sclk) begin
            if (bytec >= 1 && nframes < 16 && fb[nframes][0] == 8'h05)
                miso_q = status[7 - bitc];
        end
        if (!prev_cs && spi_cs_n) begin
            gap_run = 1;
            if (bitc != 0) partial_viol++;
            if (nframes < 16) begin
                flen[nframes] = bytec;
                if (bytec > 0 && (fb[nframes][0] == 8'h02 || fb[nframes][0] == 8'h20))
                    busy_left = post_busy;
                else if (bytec > 0 && fb[nframes][0] == 8'h05 && busy_left > 0)
                    busy_left--;
            end
            nframes++;
            miso_q = 1'b0;
        end
        prev_cs   = spi_cs_n;
        prev_sc   = spi_sclk;
        prev_mosi = spi_mosi;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic arm(input int pre, input int post);
        arm_pre  = pre;
        arm_post = post;
        arm_id   = arm_id + 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic issue(input logic op, input logic [23:0] addr, input logic [15:0] len);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_len   = len;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_cnt == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R7 done reached", (done_cnt != 0), 1);
        repeat (DIV * 4) @(negedge clk);
    endtask

    task automatic check_frames(input int p, input int q, input logic [7:0] opc,
                                input logic [23:0] addr, input int ndata);
        int c;
        chk("R3 R7 frame count", nframes, p + q + 4);
        for (int i = 0; i <= p; i++) begin
            chk("R3 pre-poll frame length", flen[i], 2);
            chk("R3 pre-poll opcode", fb[i][0], 8'h05);
        end
        chk("R4 write-enable frame length", flen[p+1], 1);
        chk("R4 write-enable opcode", fb[p+1][0], 8'h06);
        c = p + 2;
        chk("R6 command frame length", flen[c], 4 + ndata);
        chk("R5 command opcode", fb[c][0], opc);
        chk("R5 address high byte", fb[c][1], addr[23:16]);
        chk("R5 address mid byte", fb[c][2], addr[15:8]);
        chk("R5 address low byte", fb[c][3], addr[7:0]);
        for (int k = 0; k < ndata && k < 20; k++)
            chk("R6 payload byte", fb[c][4+k], pat(k));
        for (int i = p + 3; i <= p + q + 3; i++) begin
            chk("R7 post-poll frame length", flen[i], 2);
            chk("R7 post-poll opcode", fb[i][0], 8'h05);
        end
        chk("R7 single done pulse", done_cnt, 1);
        chk("R8 deselect gap", (min_gap >= DIV), 1);
        chk("R2 mosi stable while sclk high", mosi_viol, 0);
        chk("R2 whole bytes per frame", partial_viol, 0);
        chk("R2 high half length", {hi_min[15:0], hi_max[15:0]}, {16'(DIV/2), 16'(DIV/2)});
        chk("R7 idle after done", {busy, spi_cs_n}, 2'b01);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 reset outputs",
            {spi_cs_n, spi_sclk, busy, done, wr_ready}, 5'b10000);
    endtask

    task automatic t_erase();
        arm(0, 2);
        issue(1'b0, 24'h123ABC, 16'd9);
        chk("R7 busy after accept", busy, 1);
        wait_done();
        check_frames(0, 2, 8'h20, 24'h123000, 0);
    endtask

    task automatic t_program();
        arm(2, 0);
        issue(1'b1, 24'hABCDEF, 16'd5);
        wait_done();
        check_frames(2, 0, 8'h02, 24'hABCDEF, 5);
    endtask

    task automatic t_clamp_stall();
        arm(1, 1);
        stall = 1'b1;
        issue(1'b1, 24'h000100, 16'd40);
        wait_done();
        stall = 1'b0;
        check_frames(1, 1, 8'h02, 24'h000100, PAGE);
    endtask

    task automatic t_zero_len();
        arm(0, 0);
        issue(1'b1, 24'h7F0003, 16'd0);
        wait_done();
        check_frames(0, 0, 8'h02, 24'h7F0003, 0);
    endtask

    task automatic t_ignore_busy();
        int snap;
        arm(1, 1);
        issue(1'b0, 24'h005FFF, 16'd0);
        repeat (20) @(negedge clk);
        issue(1'b1, 24'hFFFFFF, 16'd3);
        wait_done();
        check_frames(1, 1, 8'h20, 24'h005000, 0);
        snap = nframes;
        repeat (200) @(negedge clk);
        chk("R9 no frame from ignored request", nframes, snap);
        chk("R9 no extra done", done_cnt, 1);
        chk("R9 engine idle", busy, 0);
    endtask

    task automatic t_abort();
        int snap;
        arm(0, 0);
        issue(1'b1, 24'h040404, 16'd8);
        repeat (100) @(negedge clk);
        chk("R10 engine active before abort", {busy, spi_cs_n}, 2'b10);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R10 outputs after abort",
            {spi_cs_n, spi_sclk, busy, wr_ready, done}, 5'b10000);
        @(negedge clk);
        snap = nframes;
        repeat (150) @(negedge clk);
        chk("R10 no frame after abort", nframes, snap);
        chk("R10 no done after abort", done_cnt, 0);
        arm(0, 1);
        issue(1'b0, 24'hFEDCBA, 16'd0);
        wait_done();
        check_frames(0, 1, 8'h20, 24'hFED000, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erase();
        t_program();
        t_clamp_stall();
        t_zero_len();
        t_ignore_busy();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

endmodule